// File: doc/BRIEF.md
# Dual-Rail Wavefront Pipeline

This block is a clocked, synthesizable model of a self-timed pipeline that carries each data bit on a pair of wires. A word is either complete DATA, where every bit pair holds a value, or NULL, where every wire is low. Words travel as alternating DATA and NULL wavefronts. No stage-enable signal moves them. A stage takes a new wavefront only when the stage after it asks for that kind of wavefront. The request a stage sends back to its predecessor is the inverse of its own completion state. Depth and word width are parameters. The default is three stages of eight bits, which acts as a three-transfer delay line. The system clock only marks the moments at which each stage may change.

Each stage runs a two-state machine. ST_NULL means the stage holds an all-zero word and reports NULL completion. ST_DATA means it holds a complete word and reports DATA completion. There are two named transitions. STEP_FILL goes from ST_NULL to ST_DATA when the successor requests data and the incoming word is complete DATA. STEP_DRAIN goes from ST_DATA to ST_NULL when the successor requests NULL and the incoming word is all NULL. Every other case is STEP_HOLD, and the stage keeps both its state and its word.

The producer drives a dual-rail word and watches `in_rfd`. While `in_rfd` is high it may present DATA. While it is low it must return its wires to NULL. The consumer watches the dual-rail output and drives `out_rfd`. It drives `out_rfd` low once it has taken a DATA word, and high once it has seen NULL.

Top module: `dr_wave_pipe`

## Requirements
- R1: Bit b of a word is the pair (t[b], f[b]). t=1,f=0 means logic 1. t=0,f=1 means logic 0. t=0,f=0 means NULL. t=1,f=1 is illegal.
- R2: `rail_fault` is high in the same cycle that any input pair is t=1,f=1. Such a word is never captured: `in_rfd` and the output stay unchanged. No stage ever holds an illegal pair.
- R3: While `rst_n` is low, and after it is released, every output rail is 0 and `in_rfd` is 1.
- R4: A stage is in ST_DATA only when every pair of its word is one-hot. It is in ST_NULL only when every wire of its word is 0. So the output is always either complete DATA or all NULL.
- R5: A stage takes STEP_FILL only when its successor requests data and its input is complete DATA. It takes STEP_DRAIN only when its successor requests NULL and its input is all NULL. A stage's request to its predecessor is the inverse of its own completion. The last stage's successor request is `out_rfd`.
- R6: An input word that mixes NULL and valid pairs leaves every stage unchanged, and `in_rfd` keeps its value.
- R7: While the output holds DATA and `out_rfd` stays 1, the output is unchanged. While the output is NULL and `out_rfd` stays 0, the output stays NULL.
- R8: With an empty pipeline and `out_rfd` at 1, a DATA word presented before a clock edge appears at the output after STAGES edges. `in_rfd` falls after the first edge.
- R9: `in_rfd` falls only after a complete DATA word was offered. It rises again only after the NULL wavefront has returned to the first stage.
- R10: DATA words leave in the order they entered, and each one is separated from the next by a NULL word at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock; stages change only on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the all-NULL state |
| in_t | input | WIDTH | True rails of the incoming word |
| in_f | input | WIDTH | False rails of the incoming word |
| in_rfd | output | 1 | 1 = first stage requests DATA, 0 = requests NULL |
| out_t | output | WIDTH | True rails of the last stage |
| out_f | output | WIDTH | False rails of the last stage |
| out_rfd | input | 1 | Consumer request: 1 = DATA wanted, 0 = NULL wanted |
| rail_fault | output | 1 | High while any input pair is the illegal t=1,f=1 |

## Verification
The case hardest to reach from the ports is a word that arrives piecemeal: some pairs are already valid while others are still NULL, and `in_rfd` is asking for data. A well-behaved producer never offers such a word. The bench therefore drives a half-formed word on purpose and holds it for several cycles. It confirms that the request and the output do not move. Only then does it complete the word and check that it travels through. A random stream follows. The consumer stalls for random lengths of time, so the bench meets the back-pressured states in which a stage holds DATA while its successor is still draining NULL.

// File: rtl/dr_pkg.sv
package dr_pkg;

    // Completion state of one stage.
    typedef enum logic {
        ST_NULL = 1'b0,
        ST_DATA = 1'b1
    } wave_t;

    // Transition taken by a stage on a clock edge.
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_FILL  = 2'd1,
        STEP_DRAIN = 2'd2
    } step_t;

endpackage

// File: rtl/dr_detect.sv
module dr_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic             is_data,
    output logic             is_null,
    output logic             has_bad
);

    logic [WIDTH-1:0] pair_valid;
    logic [WIDTH-1:0] pair_empty;
    logic [WIDTH-1:0] pair_bad;

    for (genvar b = 0; b < WIDTH; b++) begin : g_pair
        assign pair_valid[b] = rail_t[b] ^ rail_f[b];
        assign pair_empty[b] = ~(rail_t[b] | rail_f[b]);
        assign pair_bad[b]   = rail_t[b] & rail_f[b];
    end

    assign is_data = &pair_valid;
    assign is_null = &pair_empty;
    assign has_bad = |pair_bad;

endmodule

// File: rtl/dr_stage.sv
module dr_stage
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_t,
    input  logic [WIDTH-1:0] src_f,
    input  logic             succ_rfd,
    output logic [WIDTH-1:0] hold_t,
    output logic [WIDTH-1:0] hold_f,
    output logic             complete
);

    logic  src_data;
    logic  src_null;
    logic  src_bad;
    wave_t state_q;
    wave_t state_d;
    step_t step;

    dr_detect #(.WIDTH(WIDTH)) u_det (
        .rail_t  (src_t),
        .rail_f  (src_f),
        .is_data (src_data),
        .is_null (src_null),
        .has_bad (src_bad)
    );

    // Next-state and transition selection.
    always_comb begin
        state_d = state_q;
        step    = STEP_HOLD;
        unique case (state_q)
            ST_NULL: begin
                if (succ_rfd && src_data) begin
                    state_d = ST_DATA;
                    step    = STEP_FILL;
                end
            end
            ST_DATA: begin
                if (!succ_rfd && src_null) begin
                    state_d = ST_NULL;
                    step    = STEP_DRAIN;
                end
            end
            default: begin
                state_d = ST_NULL;
                step    = STEP_DRAIN;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NULL;
        else        state_q <= state_d;
    end

    // Word register, written according to the chosen transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_t <= '0;
            hold_f <= '0;
        end else begin
            unique case (step)
                STEP_FILL: begin
                    hold_t <= src_t;
                    hold_f <= src_f;
                end
                STEP_DRAIN: begin
                    hold_t <= '0;
                    hold_f <= '0;
                end
                default: ;
            endcase
        end
    end

    assign complete = (state_q == ST_DATA);

    assert_no_bad_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_t & hold_f) == '0);

    assert_bad_not_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        src_bad |=> $stable(state_q));

    assert_state_matches_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) ? ((hold_t ^ hold_f) == '1) : ((hold_t | hold_f) == '0));

    assert_fill_on_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && $past(state_q) == ST_NULL) |-> $past(succ_rfd));

    assert_drain_on_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NULL && $past(state_q) == ST_DATA) |-> !$past(succ_rfd));

    assert_mixed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_data && !src_null) |=> ($stable(state_q) && $stable(hold_t) && $stable(hold_f)));

endmodule

// File: rtl/dr_wave_pipe.sv
module dr_wave_pipe
    import dr_pkg::*;
#(
    parameter int STAGES = 3,
    parameter int WIDTH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_t,
    input  logic [WIDTH-1:0] in_f,
    output logic             in_rfd,
    output logic [WIDTH-1:0] out_t,
    output logic [WIDTH-1:0] out_f,
    input  logic             out_rfd,
    output logic             rail_fault
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] link_t [STAGES+1];
    logic [WIDTH-1:0] link_f [STAGES+1];
    logic [STAGES-1:0] done;
    logic [STAGES-1:0] rfd;
    logic in_data;
    logic in_null;

    assign link_t[0] = in_t;
    assign link_f[0] = in_f;

    dr_detect #(.WIDTH(WIDTH)) u_in_det (
        .rail_t  (in_t),
        .rail_f  (in_f),
        .is_data (in_data),
        .is_null (in_null),
        .has_bad (rail_fault)
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == LAST) begin : g_tail
            assign rfd[i] = out_rfd;
        end else begin : g_inner
            assign rfd[i] = ~done[i+1];
        end

        dr_stage #(.WIDTH(WIDTH)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_t    (link_t[i]),
            .src_f    (link_f[i]),
            .succ_rfd (rfd[i]),
            .hold_t   (link_t[i+1]),
            .hold_f   (link_f[i+1]),
            .complete (done[i])
        );
    end

    assign in_rfd = ~done[0];
    assign out_t  = link_t[STAGES];
    assign out_f  = link_f[STAGES];

    assert_fault_no_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rail_fault |=> $stable(in_rfd));

    assert_out_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done[LAST] && out_rfd) |=> ($stable(out_t) && $stable(out_f)));

    assert_out_hold_null_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!done[LAST] && !out_rfd) |=> ((out_t | out_f) == '0));

    assert_rfd_fall_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_rfd) |-> $past(in_data));

    assert_rfd_rise_after_null_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_rfd) |-> $past(in_null));

endmodule

// File: tb/sim_dr_wave_pipe.sv
module sim_dr_wave_pipe;

    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 3;
    localparam int WIDTH      = 8;
    localparam int N_WORDS    = 40;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] in_t = '0;
    logic [WIDTH-1:0] in_f = '0;
    logic             in_rfd;
    logic [WIDTH-1:0] out_t;
    logic [WIDTH-1:0] out_f;
    logic             out_rfd = 1'b1;
    logic             rail_fault;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cycles = 0;
    bit auto_sink = 1'b0;
    bit summary_done = 1'b0;

    // Reference model: occupancy and value per stage.
    bit m_full [STAGES];
    int m_val  [STAGES];
    int sent_q [$];
    bit prev_full = 1'b0;
    int prev_val  = 0;

    dr_wave_pipe #(.STAGES(STAGES), .WIDTH(WIDTH)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_t       (in_t),
        .in_f       (in_f),
        .in_rfd     (in_rfd),
        .out_t      (out_t),
        .out_f      (out_f),
        .out_rfd    (out_rfd),
        .rail_fault (rail_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic report();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // 0 = NULL, 1 = complete DATA, 2 = mixed or illegal (R1)
    function automatic int classify(input logic [WIDTH-1:0] t, input logic [WIDTH-1:0] f);
        if ((t | f) == '0) return 0;
        if ((t & f) == '0 && (t ^ f) == '1) return 1;
        return 2;
    endfunction

    // Model advance on each edge, from the R5/R6 rules.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                m_full[i] = 1'b0;
                m_val[i]  = 0;
            end
        end else begin
            bit nf [STAGES];
            int nv [STAGES];
            for (int i = 0; i < STAGES; i++) begin
                bit req;
                int scls;
                int sval;
                req = (i == STAGES-1) ? out_rfd : !m_full[i+1];
                if (i == 0) begin
                    scls = classify(in_t, in_f);
                    sval = int'(in_t);
                end else begin
                    scls = m_full[i-1] ? 1 : 0;
                    sval = m_val[i-1];
                end
                nf[i] = m_full[i];
                nv[i] = m_val[i];
                if (!m_full[i] && req && scls == 1) begin
                    nf[i] = 1'b1;
                    nv[i] = sval;
                end else if (m_full[i] && !req && scls == 0) begin
                    nf[i] = 1'b0;
                    nv[i] = 0;
                end
            end
            for (int i = 0; i < STAGES; i++) begin
                m_full[i] = nf[i];
                m_val[i]  = nv[i];
            end
        end
    end

    // Per-cycle comparison and output scoreboard.
    always @(negedge clk) begin
        logic [WIDTH-1:0] et;
        logic [WIDTH-1:0] ef;
        int oc;
        et = m_full[STAGES-1] ? WIDTH'(m_val[STAGES-1]) : '0;
        ef = m_full[STAGES-1] ? ~WIDTH'(m_val[STAGES-1]) : '0;
        check(out_t == et, "R5 out_t vs model", int'(out_t), int'(et));
        check(out_f == ef, "R5 out_f vs model", int'(out_f), int'(ef));
        check(in_rfd == !m_full[0], "R9 in_rfd vs model", int'(in_rfd), int'(!m_full[0]));
        check((out_t & out_f) == '0, "R2 no illegal pair at output", int'(out_t & out_f), 0);
        oc = classify(out_t, out_f);
        check(oc != 2, "R4 output complete or NULL", oc, 1);
        if (rst_n && oc == 1) begin
            if (!prev_full) begin
                if (sent_q.size() == 0) begin
                    check(1'b0, "R10 unexpected output word", int'(out_t), -1);
                end else begin
                    int e;
                    e = sent_q.pop_front();
                    check(int'(out_t) == e, "R10 output order", int'(out_t), e);
                end
            end else begin
                check(int'(out_t) == prev_val, "R10 NULL between words", int'(out_t), prev_val);
            end
        end
        prev_full = (oc == 1);
        prev_val  = int'(out_t);
    end

    // Randomly stalling consumer.
    always @(negedge clk) begin
        if (auto_sink) begin
            if (classify(out_t, out_f) == 1 && out_rfd && $urandom_range(0, 3) == 0)
                out_rfd <= 1'b0;
            else if (classify(out_t, out_f) == 0 && !out_rfd && $urandom_range(0, 2) == 0)
                out_rfd <= 1'b1;
        end
    end

    // Watchdog.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", cycles, WATCHDOG);
        report();
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [WIDTH-1:0] v);
        while (!in_rfd) @(negedge clk);
        wait_neg($urandom_range(0, 3));
        in_t = v;
        in_f = ~v;
        sent_q.push_back(int'(v));
        @(negedge clk);
        while (in_rfd) @(negedge clk);
        wait_neg($urandom_range(0, 2));
        in_t = '0;
        in_f = '0;
        @(negedge clk);
    endtask

    initial begin
        // R3: reset state
        wait_neg(3);
        check(out_t == '0 && out_f == '0, "R3 rails zero in reset", int'(out_t | out_f), 0);
        check(in_rfd == 1'b1, "R3 in_rfd high in reset", int'(in_rfd), 1);
        rst_n = 1'b1;
        wait_neg(2);
        check(in_rfd == 1'b1, "R3 in_rfd high after reset", int'(in_rfd), 1);

        // R8: latency through an empty pipeline
        in_t = 8'hA5;
        in_f = 8'h5A;
        sent_q.push_back(32'hA5);
        @(posedge clk);
        @(negedge clk);
        check(in_rfd == 1'b0, "R8 in_rfd falls after first edge", int'(in_rfd), 0);
        in_t = '0;
        in_f = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(out_t == 8'hA5 && out_f == 8'h5A, "R8 word at output after STAGES edges", int'(out_t), 32'hA5);

        // R7: output held while consumer keeps requesting data
        wait_neg(4);
        check(out_t == 8'hA5, "R7 output holds DATA", int'(out_t), 32'hA5);
        out_rfd = 1'b0;
        wait_neg(1);
        check((out_t | out_f) == '0, "R5 output drains on NULL request", int'(out_t | out_f), 0);
        wait_neg(3);
        check((out_t | out_f) == '0, "R7 output stays NULL", int'(out_t | out_f), 0);
        out_rfd = 1'b1;
        wait_neg(2);

        // R2: illegal pair flagged and not captured
        in_t = 8'hFF;
        in_f = 8'h01;
        #1;
        check(rail_fault == 1'b1, "R2 rail_fault on illegal pair", int'(rail_fault), 1);
        wait_neg(3);
        check(in_rfd == 1'b1, "R2 illegal word not taken", int'(in_rfd), 1);
        check((out_t | out_f) == '0, "R2 output untouched", int'(out_t | out_f), 0);
        in_t = '0;
        in_f = '0;
        #1;
        check(rail_fault == 1'b0, "R2 rail_fault clears", int'(rail_fault), 0);
        wait_neg(1);

        // R6: partially formed word is held off
        in_t = 8'h0F;
        in_f = 8'h00;
        wait_neg(4);
        check(in_rfd == 1'b1, "R6 mixed word leaves in_rfd", int'(in_rfd), 1);
        check((out_t | out_f) == '0, "R6 mixed word leaves output", int'(out_t | out_f), 0);
        in_f = 8'hF0;
        sent_q.push_back(32'h0F);
        while (in_rfd) @(negedge clk);
        in_t = '0;
        in_f = '0;
        wait_neg(5);
        check(out_t == 8'h0F && out_f == 8'hF0, "R1 completed word delivered", int'(out_t), 32'h0F);

        // R10: random stream under random back-pressure
        auto_sink = 1'b1;
        for (int k = 0; k < N_WORDS; k++) begin
            send_word(WIDTH'($urandom_range(0, 255)));
        end
        while (sent_q.size() != 0) @(negedge clk);
        wait_neg(10);
        check(sent_q.size() == 0, "R10 every word delivered", sent_q.size(), 0);
        report();
    end

endmodule